// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog driven from one 32-bit control word. While enabled it counts clock cycles through a selectable prescaler until a selectable timeout elapses. The first expiry is a warning. It sets a warning flag, optionally raises an interrupt, and starts a short grace interval. If software has not cleared the warning flag when the grace interval runs out, the block sets a reset flag. When reset is enabled, it also drives a one-cycle system-reset pulse.

Software services the watchdog by writing the control word with the self-clearing restart bit set. This reloads the timeout for the timeout select value being written. Both status flags are cleared by writing 1 to them. A core reset returns the control word to its default value but keeps the reset flag, so software can see after the reset that the watchdog caused it. Only the power-on reset clears the reset flag.

Top module: `twostage_wdt`

## Requirements
- R1: After power-on reset the control word reads 0x00000400, meaning prescale select 1 and every other field 0. `irq` and `sys_rst_pulse` are low.
- R2: Prescale select (bits 11:10) values 0, 1, 2 and 3 make one timer tick every 1, 256, 2048 and 65536 clock cycles. The first expiry occurs exactly timeout × divisor cycles after the write edge that restarts an enabled timer.
- R3: Timeout select s (bits 5:4) sets the timeout to 2^(BASE_EXP + 2s) ticks.
- R4: Writing 1 to the warning flag (bit 3) or the reset flag (bit 2) clears that flag. Writing 0 to either flag leaves it unchanged.
- R5: Writing 1 to the restart bit (bit 0) reloads the counter with the timeout selected by the written bits 5:4. The restart bit always reads 0. The counter runs only while the enable bit (bit 7) is 1.
- R6: An expiry while the warning flag is 0 sets the warning flag and reloads the counter with GRACE_TICKS ticks. `irq` equals the warning flag AND the interrupt enable (bit 6).
- R7: An expiry while the warning flag is 1 and reset enable (bit 1) is 1 sets the reset flag and drives `sys_rst_pulse` high for exactly one cycle, GRACE_TICKS × divisor cycles after the warning. With reset enable 0, neither of these happens.
- R8: Clearing the enable bit without a restart freezes the count. Setting it again resumes from the held count, so expiry is delayed by exactly the paused interval.
- R9: A core reset loads 0x00000400 but keeps the reset flag (bit 2). A power-on reset clears the reset flag too.
- R10: Bits 31:12 and bit 8 read 0. The freeze bit (bit 9) is stored and read back but does not change counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and reference tick source |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| core_rst_n | input | 1 | Synchronous active-low core reset; keeps the reset flag |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value written to the control word |
| ctrl_q | output | 32 | Current control word as read back |
| irq | output | 1 | Warning interrupt level |
| sys_rst_pulse | output | 1 | One-cycle system-reset request |

## Verification
Some properties are checked by assertions on every cycle. The count holds whenever no tick or reload occurs. A warning always leaves exactly the grace count in the counter. The system-reset pulse never lasts more than one cycle. The reset flag only rises while the warning flag is set. A write of 1 to a flag clears it and a write of 0 keeps it.

Other behaviours can only be shown by the bench scenarios. These are the exact cycle of each expiry under each prescaler and timeout setting, the delay added by a pause, the effect of a restart write issued before expiry, and which fields survive a core reset.

// File: rtl/twostage_wdt_pkg.sv
// Package: shared field positions, control-word type and prescaler table
// for the two-stage watchdog. Assumes a 32-bit control word.
package twostage_wdt_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned PRE_W    = 16;

    // Field positions that software decodes
    localparam int unsigned POS_CLKSEL = 10;
    localparam int unsigned POS_FREEZE = 9;
    localparam int unsigned POS_EN     = 7;
    localparam int unsigned POS_IE     = 6;
    localparam int unsigned POS_TSEL   = 4;
    localparam int unsigned POS_WARN   = 3;
    localparam int unsigned POS_BITE   = 2;
    localparam int unsigned POS_RSTEN  = 1;
    localparam int unsigned POS_KICK   = 0;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       freeze;
        logic       en;
        logic       irq_en;
        logic [1:0] tsel;
        logic       warn_flag;
        logic       bite_flag;
        logic       rst_en;
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_DEFAULT = '{
        clk_sel:   2'd1,
        freeze:    1'b0,
        en:        1'b0,
        irq_en:    1'b0,
        tsel:      2'd0,
        warn_flag: 1'b0,
        bite_flag: 1'b0,
        rst_en:    1'b0
    };

    // Last prescaler count value (divisor - 1) for a select code
    function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
        case (sel)
            2'd0:    return PRE_W'(0);
            2'd1:    return PRE_W'(255);
            2'd2:    return PRE_W'(2047);
            default: return PRE_W'(65535);
        endcase
    endfunction

    // Assemble the read-back view of the control word
    function automatic logic [WORD_W-1:0] cfg_view(input wdt_cfg_t c);
        logic [WORD_W-1:0] v;
        v = '0;
        v[POS_CLKSEL +: 2] = c.clk_sel;
        v[POS_FREEZE]      = c.freeze;
        v[POS_EN]          = c.en;
        v[POS_IE]          = c.irq_en;
        v[POS_TSEL +: 2]   = c.tsel;
        v[POS_WARN]        = c.warn_flag;
        v[POS_BITE]        = c.bite_flag;
        v[POS_RSTEN]       = c.rst_en;
        return v;
    endfunction

endpackage

// File: rtl/twostage_wdt_cfg.sv
// Module: control word storage with write-1-to-clear status flags.
// Assumes warn_evt and bite_evt are single-cycle events from the counter.
// A hardware set and a software clear in the same cycle resolve to set.
module twostage_wdt_cfg
    import twostage_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              warn_evt,
    input  logic              bite_evt,
    output wdt_cfg_t          cfg_q
);

    logic clr_warn;
    logic clr_bite;
    logic unused_wr_bits;

    assign clr_warn       = wr_en & wr_data[POS_WARN];
    assign clr_bite       = wr_en & wr_data[POS_BITE];
    assign unused_wr_bits = ^{wr_data[WORD_W-1:POS_CLKSEL+2], wr_data[8], wr_data[POS_KICK]};

    // Purpose: hold the control fields and update the sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_DEFAULT;
        end else if (!core_rst_n) begin
            cfg_q           <= CFG_DEFAULT;
            cfg_q.bite_flag <= cfg_q.bite_flag;
        end else begin
            if (wr_en) begin
                cfg_q.clk_sel <= wr_data[POS_CLKSEL +: 2];
                cfg_q.freeze  <= wr_data[POS_FREEZE];
                cfg_q.en      <= wr_data[POS_EN];
                cfg_q.irq_en  <= wr_data[POS_IE];
                cfg_q.tsel    <= wr_data[POS_TSEL +: 2];
                cfg_q.rst_en  <= wr_data[POS_RSTEN];
            end
            cfg_q.warn_flag <= (cfg_q.warn_flag & ~clr_warn) | warn_evt;
            cfg_q.bite_flag <= (cfg_q.bite_flag & ~clr_bite) | bite_evt;
        end
    end

    // R4: a 1 written to the warning flag clears it unless a warning coincides
    a_r4_warn_w1c: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
        (wr_en && wr_data[POS_WARN] && !warn_evt) |=> !cfg_q.warn_flag);

    // R4: a 0 written to the reset flag keeps it set
    a_r4_bite_keep: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
        (wr_en && !wr_data[POS_BITE] && cfg_q.bite_flag) |=> cfg_q.bite_flag);

    // R7: the reset flag only rises while the warning flag was set
    a_r7_bite_after_warn: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
        $rose(cfg_q.bite_flag) |-> $past(cfg_q.warn_flag));

endmodule

// File: rtl/twostage_wdt_presc.sv
// Module: clock prescaler producing a one-cycle tick every divisor cycles.
// Assumes the select may change at any time; an out-of-range phase after a
// shrink of the divisor ticks at once and wraps to zero.
module twostage_wdt_presc
    import twostage_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last;

    assign last = presc_last(sel);
    assign tick = run && (phase_q >= last);

    // Purpose: advance the phase while running, clear it on restart or wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !core_rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            if (phase_q >= last) phase_q <= '0;
            else                 phase_q <= phase_q + PRE_W'(1);
        end
    end

    // R8: a stopped prescaler holds its phase
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
        (!run && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/twostage_wdt_count.sv
// Module: down counter with the two-stage expiry sequencing.
// Assumes tick is one cycle wide and load has priority over a tick.
// A count of zero means stopped until the next load.
module twostage_wdt_count #(
    parameter int unsigned BASE_EXP    = 14,
    parameter int unsigned GRACE_TICKS = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_rst_n,
    input  logic       load,
    input  logic [1:0] load_tsel,
    input  logic       tick,
    input  logic       warn_flag,
    input  logic       rst_en,
    output logic       warn_evt,
    output logic       bite_evt,
    output logic       bite_q
);

    localparam int unsigned CNT_W = BASE_EXP + 7;
    localparam logic [CNT_W-1:0] GRACE_CNT = CNT_W'(GRACE_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    function automatic logic [CNT_W-1:0] timeout_of(input logic [1:0] s);
        return CNT_W'(1) << (BASE_EXP + 2 * int'(s));
    endfunction

    assign expire   = tick && !load && (cnt_q == CNT_W'(1));
    assign warn_evt = expire && !warn_flag;
    assign bite_evt = expire && warn_flag && rst_en;

    // Purpose: reload, count down, and arm the grace interval
    always_ff @(posedge clk) begin
        if (!rst_n || !core_rst_n) begin
            cnt_q <= timeout_of(2'd0);
        end else if (load) begin
            cnt_q <= timeout_of(load_tsel);
        end else if (tick && cnt_q != '0) begin
            if (cnt_q == CNT_W'(1)) cnt_q <= warn_flag ? '0 : GRACE_CNT;
            else                    cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Purpose: register the system-reset request as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !core_rst_n) bite_q <= 1'b0;
        else                       bite_q <= bite_evt;
    end

    // R8: no tick and no load means the count is frozen
    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
        (!tick && !load) |=> $stable(cnt_q));

    // R6: a warning leaves exactly the grace count
    a_r6_grace_reload: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
        warn_evt |=> (cnt_q == GRACE_CNT));

    // R7: the system-reset pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
        bite_q |=> !bite_q);

endmodule

// File: rtl/twostage_wdt.sv
// Module: two-stage watchdog top. Ties the control word, prescaler and
// expiry counter together. Assumes clk is also the reference tick.
module twostage_wdt
    import twostage_wdt_pkg::*;
#(
    parameter int unsigned BASE_EXP    = 14,
    parameter int unsigned GRACE_TICKS = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        core_rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_q,
    output logic        irq,
    output logic        sys_rst_pulse
);

    wdt_cfg_t cfg;
    logic     kick;
    logic     tick;
    logic     warn_evt;
    logic     bite_evt;

    assign kick = wr_en & wr_data[POS_KICK];

    twostage_wdt_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .warn_evt   (warn_evt),
        .bite_evt   (bite_evt),
        .cfg_q      (cfg)
    );

    twostage_wdt_presc u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .run        (cfg.en),
        .restart    (kick),
        .sel        (cfg.clk_sel),
        .tick       (tick)
    );

    twostage_wdt_count #(
        .BASE_EXP    (BASE_EXP),
        .GRACE_TICKS (GRACE_TICKS)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .load       (kick),
        .load_tsel  (wr_data[POS_TSEL +: 2]),
        .tick       (tick),
        .warn_flag  (cfg.warn_flag),
        .rst_en     (cfg.rst_en),
        .warn_evt   (warn_evt),
        .bite_evt   (bite_evt),
        .bite_q     (sys_rst_pulse)
    );

    assign ctrl_q = cfg_view(cfg);
    assign irq    = cfg.warn_flag & cfg.irq_en;

    // R7: a reset pulse is always accompanied by the reset flag
    a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
        sys_rst_pulse |-> ctrl_q[POS_BITE]);

endmodule

// File: tb/twostage_wdt_tb.sv
module twostage_wdt_tb;

    localparam int B = 4;
    localparam int G = 16;

    logic        clk = 1'b0;
    logic        rst_n, core_rst_n, wr_en;
    logic [31:0] wr_data, ctrl_q;
    logic        irq, sys_rst_pulse;

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 0;
    bit prev_warn = 0;
    bit done = 0;

    typedef struct {
        int    kind;   // 0 warning, 1 system reset
        int    at;
        string req;
    } ev_t;
    ev_t sb[$];

    twostage_wdt #(.BASE_EXP(B), .GRACE_TICKS(G)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
        .irq(irq), .sys_rst_pulse(sys_rst_pulse)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int at, input string req);
        ev_t e;
        e.kind = kind; e.at = at; e.req = req;
        sb.push_back(e);
    endtask

    task automatic seen(input int kind);
        ev_t e;
        n_cmp++;
        if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL %s unexpected event: actual kind %0d at %0d expected none",
                     (kind == 0) ? "R6" : "R7", kind, cyc);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                n_bad++;
                $display("FAIL %s event: actual kind %0d at %0d expected kind %0d at %0d",
                         e.req, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // Monitor: pops the scoreboard on each warning edge and reset pulse
    always @(negedge clk) begin
        if (mon_on && rst_n && core_rst_n) begin
            if (ctrl_q[3] && !prev_warn) seen(0);
            if (sys_rst_pulse) seen(1);
        end
        prev_warn = ctrl_q[3];
    end

    task automatic wr(input logic [31:0] v, output int edge_no);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v; edge_no = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        int e, e2, e3;
        rst_n = 1'b0; core_rst_n = 1'b1; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; mon_on = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "ctrl after reset", ctrl_q, 32'h400);
        chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
        chk("R1", "reset pulse after reset", {31'b0, sys_rst_pulse}, 32'h0);

        // R2 R3 R6 R7: divisor 1, timeout 16, interrupt and reset enabled
        wr(32'h0000_00C3, e);
        expect_ev(0, e + 16, "R3");
        expect_ev(1, e + 16 + G, "R7");
        wait_to(e + 20);
        chk("R6", "irq with warning and enable", {31'b0, irq}, 32'h1);
        wait_to(e + 40);
        chk("R7", "reset flag set", {31'b0, ctrl_q[2]}, 32'h1);

        // R4 write-1-to-clear
        wr(32'h0, e);
        chk("R4", "flags kept on write of 0", ctrl_q, 32'h0C);
        wr(32'h08, e);
        chk("R4", "warning cleared, reset flag kept", ctrl_q, 32'h04);

        // R9 core reset keeps reset flag, power-on clears it
        @(negedge clk); core_rst_n = 1'b0;
        repeat (2) @(negedge clk); core_rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "after core reset", ctrl_q, 32'h404);
        rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "after power-on reset", ctrl_q, 32'h400);

        // R3 timeout select 3, no interrupt, no reset enable
        wr(32'h0000_00B1, e);
        expect_ev(0, e + 1024, "R3");
        wait_to(e + 1024 + G + 20);
        chk("R7", "no reset when disabled", ctrl_q, 32'hB8);
        chk("R6", "irq masked", {31'b0, irq}, 32'h0);
        wr(32'h08, e);
        chk("R4", "cleared and stopped", ctrl_q, 32'h0);

        // R2 R5 divisor 256 with a service write before expiry
        wr(32'h0000_0481, e);
        wait_to(e + 2000);
        wr(32'h0000_0481, e2);
        expect_ev(0, e2 + 16 * 256, "R5");
        wait_to(e2 + 100);
        chk("R5", "restart bit reads 0", ctrl_q, 32'h480);
        wait_to(e2 + 16 * 256 + 10);
        wr(32'h0000_0408, e);
        chk("R4", "stopped with flag cleared", ctrl_q, 32'h400);

        // R2 divisor 2048, full two-stage sequence
        wr(32'h0000_08C3, e);
        expect_ev(0, e + 16 * 2048, "R2");
        expect_ev(1, e + 16 * 2048 + G * 2048, "R7");
        wait_to(e + 16 * 2048 + 5);
        chk("R6", "irq at divisor 2048", {31'b0, irq}, 32'h1);
        wait_to(e + 16 * 2048 + G * 2048 + 5);
        wr(32'h0000_080C, e);
        chk("R4", "both flags cleared", ctrl_q, 32'h800);

        // R8 pause and resume
        wr(32'h0000_0081, e);
        wait_to(e + 5);
        wr(32'h0, e2);
        wait_to(e2 + 30);
        chk("R8", "no expiry while paused", ctrl_q, 32'h0);
        wr(32'h0000_0080, e3);
        expect_ev(0, e + 16 + (e3 - e2), "R8");
        wait_to(e + 16 + (e3 - e2) + 5);
        wr(32'h08, e);

        // R10 reserved bits and freeze bit
        wr(32'hFFFF_F200, e);
        chk("R10", "reserved bits read 0", ctrl_q, 32'h200);
        wr(32'h0000_0281, e);
        expect_ev(0, e + 16, "R10");
        wait_to(e + 25);
        chk("R10", "freeze has no effect", ctrl_q, 32'h288);

        repeat (4) @(negedge clk);
        chk("R6", "scoreboard drained", sb.size(), 32'h0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 watchdog: actual running expected finished");
            finish_run();
        end
    end

endmodule